// File: doc/BRIEF.md
# Program Memory Checksum Engine

This block computes the 16-bit verification checksum of a program memory image. After a start pulse it walks the image through a single-outstanding read port. It adds each 12-bit word, zero-extended to 16 bits, into an accumulator. It finishes with a one-cycle done pulse and leaves the result on `sum_o`.

The accumulator is seeded in the cycle that the start pulse is accepted. The seed is the configuration word masked to its low nibble plus the constant 0x0FF0. Bit 3 of the configuration word selects the variant:

- **Bit 3 = 1 (unprotected):** the walk covers addresses 0x000 to 0x7FF.
- **Bit 3 = 0 (protected):** the walk covers only 0x000 to 0x03F. The seed also gets a packed ID value, built from the low nibble of each of the four ID words with ID0 in the most significant nibble.

The controller has three states:

- `ST_IDLE` waits for `start_i`. On start it goes to `ST_FETCH` (transition *launch*), which loads the seed and clears the address.
- `ST_FETCH` holds `rd_req_o` high. Each `rd_valid_i` accepts one word. It stays in `ST_FETCH` on a non-final word (transition *step*, address plus one). It goes to `ST_DONE` on the final word (transition *finish*).
- `ST_DONE` raises `done_o` for one cycle and returns to `ST_IDLE` (transition *retire*).

Top module: `prog_sum_engine`

## Requirements
- R1: With configuration bit 3 = 1, the result is the low 16 bits of the sum of words 0x000..0x7FF, plus (configuration word AND 0x00F), plus 0x0FF0. An erased image (all 0xFFF, configuration 0xFFF) gives 0x07FF.
- R2: With configuration bit 3 = 0, only words 0x000..0x03F are read (64 reads). The result adds the packed ID value to the R1 terms.
- R3: The packed ID value is {ID0[3:0], ID1[3:0], ID2[3:0], ID3[3:0]}, where ID0 sits in `id_words_i[11:0]` and IDk in `id_words_i[12k+11:12k]`. Upper ID bits have no effect.
- R4: Carries beyond bit 15 are discarded. Each memory word is added zero-extended.
- R5: `rd_req_o` stays high with `rd_addr_o` stable until `rd_valid_i`. Addresses start at 0 and rise by one per accepted word. At most one read is outstanding.
- R6: `busy_o` rises in the cycle after the start pulse is accepted. `done_o` is high for exactly one cycle per run, after the last word is accepted, and `busy_o` is low after it.
- R7: A start pulse while `busy_o` is high is ignored. The run neither restarts nor reads extra words.
- R8: After reset, `sum_o`, `busy_o`, `done_o` and `rd_req_o` are 0. `sum_o` holds the finished result until the next accepted start.
- R9: The configuration word and ID words are used only in the start cycle. Changing them during a run has no effect on the result or the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cfg_word_i | input | 12 | Configuration word; bit 3 = 0 means protected |
| id_words_i | input | 48 | Four ID words, ID0 in bits [11:0] |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 11 | Read address |
| rd_valid_i | input | 1 | Read data valid, one cycle per request |
| rd_data_i | input | 12 | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 16 | Checksum result |

## Verification
The bench targets the following corner cases:

- **Erased unprotected image.** It must give exactly 0x07FF. A design that kept more than 16 bits, or forgot the 0x0FF0 term or the masking, would give another value.
- **Protected runs.** IDs whose upper bits are set check that only 64 words are read and that the nibbles are packed in the right order. A design that swapped the order or left out the mask would miss 0x21EB on the erased protected image.
- **Start re-pulsed mid-run.** A design that restarted would show extra reads and a second address sequence.
- **Configuration and IDs flipped mid-run.** A design that reread them late would change its range or its seed.
- **Varying read latency.** A design that advanced the address without a valid would fail the address checks made on every clock.

// File: rtl/psum_pkg.sv
package psum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } psum_state_e;
endpackage

// File: rtl/psum_ctrl.sv
module psum_ctrl
    import psum_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PROT_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              prot_i,
    input  logic              rd_valid_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              load_o,
    output logic              add_o
);
    localparam logic [ADDR_W-1:0] FULL_LAST = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] PROT_LAST = ADDR_W'(PROT_WORDS - 1);

    psum_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              prot_q;
    logic              last_hit;

    assign last_hit = (addr_q == (prot_q ? PROT_LAST : FULL_LAST));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: if (rd_valid_i && last_hit) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_o   = (state_q == ST_IDLE) && start_i;
        add_o    = (state_q == ST_FETCH) && rd_valid_i;
        rd_req_o = (state_q == ST_FETCH);
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            prot_q <= 1'b0;
        end else if (load_o) begin
            addr_q <= '0;
            prot_q <= prot_i;
        end else if (add_o && !last_hit) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign rd_addr_o = addr_q;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_o && !last_hit |=> rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));
    // R2
    prot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && prot_q |-> rd_addr_o <= PROT_LAST);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) && start_i && !rd_valid_i |=>
        (state_q == ST_FETCH) && $stable(rd_addr_o));
endmodule

// File: rtl/psum_seed.sv
module psum_seed #(
    parameter int               WORD_W   = 12,
    parameter int               SUM_W    = 16,
    parameter int               N_ID     = 4,
    parameter logic [WORD_W-1:0] CFG_MASK = 12'h00F,
    parameter logic [SUM_W-1:0]  BIAS     = 16'h0FF0
) (
    input  logic [WORD_W-1:0]      cfg_i,
    input  logic [N_ID*WORD_W-1:0] ids_i,
    input  logic                   prot_i,
    output logic [SUM_W-1:0]       seed_o
);
    localparam logic [WORD_W-1:0] NIB_MASK = WORD_W'(4'hF);

    logic [SUM_W-1:0] term [N_ID];
    logic [SUM_W-1:0] chain [N_ID+1];

    assign chain[0] = '0;

    generate
        for (genvar k = 0; k < N_ID; k++) begin : g_nib
            assign term[k]    = SUM_W'(ids_i[k*WORD_W +: WORD_W] & NIB_MASK)
                                << (SUM_W - 4*(k+1));
            assign chain[k+1] = chain[k] | term[k];
        end
    endgenerate

    assign seed_o = SUM_W'(cfg_i & CFG_MASK) + BIAS
                  + (prot_i ? chain[N_ID] : '0);
endmodule

// File: rtl/psum_accum.sv
module psum_accum #(
    parameter int WORD_W = 12,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SUM_W-1:0]  seed_i,
    input  logic              add_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [SUM_W-1:0]  acc_o
);
    logic [SUM_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (load_i) acc_q <= seed_i;
        else if (add_i)  acc_q <= acc_q + {{(SUM_W-WORD_W){1'b0}}, data_i};
    end

    assign acc_o = acc_q;

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !add_i |=> $stable(acc_o));
endmodule

// File: rtl/prog_sum_engine.sv
module prog_sum_engine #(
    parameter int ADDR_W     = 11,
    parameter int WORD_W     = 12,
    parameter int SUM_W      = 16,
    parameter int N_ID       = 4,
    parameter int PROT_WORDS = 64,
    parameter int CP_BIT     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [WORD_W-1:0]      cfg_word_i,
    input  logic [N_ID*WORD_W-1:0] id_words_i,
    output logic                   rd_req_o,
    output logic [ADDR_W-1:0]      rd_addr_o,
    input  logic                   rd_valid_i,
    input  logic [WORD_W-1:0]      rd_data_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [SUM_W-1:0]       sum_o
);
    logic             prot_now;
    logic             load_w, add_w;
    logic [SUM_W-1:0] seed_w;

    assign prot_now = ~cfg_word_i[CP_BIT];

    psum_ctrl #(.ADDR_W(ADDR_W), .PROT_WORDS(PROT_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prot_i(prot_now),
        .rd_valid_i(rd_valid_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .busy_o(busy_o), .done_o(done_o), .load_o(load_w), .add_o(add_w)
    );

    psum_seed #(.WORD_W(WORD_W), .SUM_W(SUM_W), .N_ID(N_ID)) u_seed (
        .cfg_i(cfg_word_i), .ids_i(id_words_i), .prot_i(prot_now), .seed_o(seed_w)
    );

    psum_accum #(.WORD_W(WORD_W), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .seed_i(seed_w),
        .add_i(add_w), .data_i(rd_data_i), .acc_o(sum_o)
    );

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start_i |=> $stable(sum_o));
    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && rd_req_o && rd_addr_o == '0);
endmodule

// File: tb/sim_prog_sum_engine.sv
module sim_prog_sum_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg = 12'hFFF;
    logic [47:0] ids = '0;
    logic        rd_req;
    logic [10:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [11:0] rd_data = '0;
    logic        busy, done;
    logic [15:0] sum;

    always #4 clk = ~clk;

    prog_sum_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_word_i(cfg),
        .id_words_i(ids), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_valid_i(rd_valid), .rd_data_i(rd_data), .busy_o(busy),
        .done_o(done), .sum_o(sum)
    );

    logic [11:0] mem [0:2047];
    int n_run = 0, n_fail = 0;
    int lat = 0, wcnt = 0, exp_addr = 0, reads = 0, dones = 0;
    bit done_seen = 0;
    logic [15:0] done_sum;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic int model(input logic [11:0] c, input logic [47:0] i);
        int s = 0;
        int last = c[3] ? 2047 : 63;
        for (int a = 0; a <= last; a++) s += int'(mem[a]);
        s += int'(c & 12'h00F) + 'h0FF0;
        if (!c[3])
            s += (int'(i[3:0]) << 12) | (int'(i[15:12]) << 8)
               | (int'(i[27:24]) << 4) | int'(i[39:36]);
        return s & 'hFFFF;
    endfunction

    // per-clock reference: address sequence, done count, responder
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                rd_valid = 1'b0;
                wcnt = 0;
                reads++;
                exp_addr++;
            end
            if (done) begin
                dones++;
                done_sum = sum;
                done_seen = 1'b1;
            end
            if (rd_req) begin
                // R5 address order
                chk(rd_addr == 11'(exp_addr), "R5", "read address", int'(rd_addr), exp_addr);
                if (wcnt >= lat) begin
                    rd_valid = 1'b1;
                    rd_data = mem[rd_addr];
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic run(input logic [11:0] c, input logic [47:0] i, input int l,
                       input bit poke_start, input bit poke_in, input string req);
        int expv = model(c, i);
        int n = c[3] ? 2048 : 64;
        lat = l; cfg = c; ids = i;
        reads = 0; exp_addr = 0; dones = 0; done_seen = 0; wcnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R6 busy in the cycle after start
        chk(busy == 1'b1, "R6", "busy after start", int'(busy), 1);
        while (!done_seen) begin
            @(negedge clk);
            start = (poke_start && reads >= 10 && reads < 14);
            if (poke_in && reads == 5) begin
                cfg = ~c;
                ids = ~i;
            end
        end
        start = 1'b0;
        chk(done_sum == 16'(expv), req, "checksum", int'(done_sum), expv);
        chk(reads == n, req, "read count", reads, n);
        repeat (4) @(negedge clk);
        chk(dones == 1, "R6", "done pulses", dones, 1);
        chk(busy == 1'b0, "R6", "busy after done", int'(busy), 0);
        // R8 hold after done
        chk(sum == 16'(expv), "R8", "sum held", int'(sum), expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = 12'hFFF;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(sum == 16'h0 && busy == 0 && done == 0 && rd_req == 0, "R8",
            "reset outputs", {sum, 1'b0, busy, done, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 erased unprotected
        run(12'hFFF, 48'h0, 0, 0, 0, "R1");
        chk(sum == 16'h07FF, "R1", "erased value", int'(sum), 'h07FF);

        // R3 protected erased, IDs with upper bits set
        run(12'hFF7, {12'hFF4, 12'hFF3, 12'hFF2, 12'hFF1}, 1, 0, 0, "R3");
        chk(sum == 16'h21EB, "R3", "packed ID order", int'(sum), 'h21EB);

        // R4 random unprotected image, wraps past 16 bits
        for (int a = 0; a < 2048; a++) mem[a] = 12'($urandom);
        run(12'hA5B, 48'h0, 2, 0, 0, "R4");

        // R2 random protected
        run(12'h3F2, {12'h9C7, 12'h35E, 12'hB0A, 12'h4D6}, 0, 0, 0, "R2");

        // R7 start while busy
        run(12'h0F0, {12'h111, 12'h222, 12'h333, 12'h444}, 1, 1, 0, "R7");

        // R9 inputs changed mid-run
        run(12'h7FC, {12'h0AB, 12'h0CD, 12'h0EF, 12'h012}, 0, 0, 1, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule